// File: doc/BRIEF.md
# Recursion-Compressed Commit Return Stack

This block holds return addresses that are known to be correct: it changes only when a call or a return instruction retires, and it never rolls back. Every slot keeps a return address and a small repeat counter. When the same return address is pushed again while it is already on top, as in a recursive call, the counter is raised and no new slot is used. A return first lowers the counter and only moves the stack pointer once the counter is zero. Repeated returns through a recursion therefore reuse one slot.

Retirement events arrive on one valid/ready channel, one per cycle. A flag on the channel says whether the event is a push or a pop. While reset is released, ready is always high, so the channel never applies back-pressure. While reset is held, ready is low. A transfer happens on a rising edge where both valid and ready are high. When valid is low, nothing changes.

The block shows its committed pointer and the entry at that pointer. It also has a second, combinational read port. A speculative predictor outside the block drives that port with its own pointer to fetch the address and counter at any slot. The pointer wraps modulo the depth, so a stack that overflows overwrites its oldest slots.

Top module: `crs_commit_stack`

## Requirements
- R1: While reset is held, `cmt_ready` is 0. After reset, `top_ptr` is 0 and every slot reads address 0 with counter 0.
- R2: `cmt_ready` is 1 in every cycle outside reset. A transfer occurs on a rising edge where `cmt_valid` and `cmt_ready` are both 1, and at most one transfer happens per cycle.
- R3: A push (`cmt_push`=1) folds when its address equals `top_addr` and `top_ctr` is below its maximum (2^CTR_W-1). On a fold, `top_ptr` holds, `top_ctr` rises by one and `top_addr` is unchanged.
- R4: A push that does not fold advances `top_ptr` by one and writes the address with counter 0 at the new slot. This includes a push onto a saturated counter.
- R5: A pop (`cmt_push`=0) with a nonzero `top_ctr` lowers the counter by one and leaves `top_ptr` unchanged.
- R6: A pop with `top_ctr` equal to 0 lowers `top_ptr` by one, and the pointer wraps from 0 to DEPTH-1. No slot contents change.
- R7: A growing push at `top_ptr` = DEPTH-1 wraps the pointer to 0 and overwrites that slot.
- R8: `rd_addr`/`rd_ctr` give, combinationally, the slot selected by `rd_idx` as it stands before the next edge. A write to that slot in the same cycle shows only after the edge.
- R9: `top_addr`/`top_ctr` always equal the contents of slot `top_ptr`.
- R10: In a cycle with `cmt_valid`=0, `top_ptr` and every slot stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmt_valid | input | 1 | A retirement event is offered |
| cmt_ready | output | 1 | The event is accepted (high outside reset) |
| cmt_push | input | 1 | 1 = retired call (push), 0 = retired return (pop) |
| cmt_addr | input | ADDR_W | Return address for a push |
| top_ptr | output | PTR_W | Committed stack pointer |
| top_addr | output | ADDR_W | Address at the committed top |
| top_ctr | output | CTR_W | Repeat counter at the committed top |
| rd_idx | input | PTR_W | Slot index for the lookup port |
| rd_addr | output | ADDR_W | Address at slot `rd_idx` |
| rd_ctr | output | CTR_W | Repeat counter at slot `rd_idx` |

## Verification
Two things can touch the same slot in the same cycle: a committed write and a lookup on the external read port. The bench provokes this by pointing `rd_idx` at the slot the pending event will write, which is the current top for a fold or a counter drop and the slot above it for a growing push. It checks that the port returns the old contents before the edge and the new contents once a later lookup hits that slot. A long pseudo-random mix of pushes over three addresses, pops and idle cycles drives counters into saturation and the pointer around both wrap points. The bench compares each cycle against an arithmetic model.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [2:0] {
    CRS_IDLE    = 3'd0,
    CRS_FOLD    = 3'd1,
    CRS_GROW    = 3'd2,
    CRS_CTR_DN  = 3'd3,
    CRS_PTR_DN  = 3'd4
  } crs_op_e;
endpackage

// File: rtl/crs_entry_bank.sv
module crs_entry_bank #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int CTR_W  = 2,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  widx,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [CTR_W-1:0]  wctr,
  input  logic [PTR_W-1:0]  ra_idx,
  output logic [ADDR_W-1:0] ra_addr,
  output logic [CTR_W-1:0]  ra_ctr,
  input  logic [PTR_W-1:0]  rb_idx,
  output logic [ADDR_W-1:0] rb_addr,
  output logic [CTR_W-1:0]  rb_ctr
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [CTR_W-1:0]  ctr_q  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        ctr_q[g]  <= '0;
      end else if (we && (widx == PTR_W'(g))) begin
        addr_q[g] <= waddr;
        ctr_q[g]  <= wctr;
      end
    end
  end

  assign ra_addr = addr_q[ra_idx];
  assign ra_ctr  = ctr_q[ra_idx];
  assign rb_addr = addr_q[rb_idx];
  assign rb_ctr  = ctr_q[rb_idx];
endmodule

// File: rtl/crs_ptr_ctl.sv
module crs_ptr_ctl
  import crs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int CTR_W  = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              is_push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CTR_W-1:0]  cur_ctr,
  output logic [PTR_W-1:0]  sp,
  output logic              we,
  output logic [PTR_W-1:0]  widx,
  output logic [ADDR_W-1:0] waddr,
  output logic [CTR_W-1:0]  wctr
);
  crs_op_e          op;
  logic [PTR_W-1:0] sp_q, sp_d;

  always_comb begin
    op = CRS_IDLE;
    if (fire) begin
      if (is_push) begin
        op = (push_addr == cur_addr && cur_ctr != CTR_MAX) ? CRS_FOLD : CRS_GROW;
      end else begin
        op = (cur_ctr != '0) ? CRS_CTR_DN : CRS_PTR_DN;
      end
    end
  end

  always_comb begin
    sp_d  = sp_q;
    we    = 1'b0;
    widx  = sp_q;
    waddr = cur_addr;
    wctr  = cur_ctr;
    unique case (op)
      CRS_FOLD: begin
        we   = 1'b1;
        wctr = cur_ctr + CTR_W'(1);
      end
      CRS_GROW: begin
        sp_d  = sp_q + PTR_W'(1);
        we    = 1'b1;
        widx  = sp_q + PTR_W'(1);
        waddr = push_addr;
        wctr  = '0;
      end
      CRS_CTR_DN: begin
        we   = 1'b1;
        wctr = cur_ctr - CTR_W'(1);
      end
      CRS_PTR_DN: sp_d = sp_q - PTR_W'(1);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  assign sp = sp_q;
endmodule

// File: rtl/crs_commit_stack.sv
module crs_commit_stack #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int CTR_W  = 2,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmt_valid,
  output logic              cmt_ready,
  input  logic              cmt_push,
  input  logic [ADDR_W-1:0] cmt_addr,
  output logic [PTR_W-1:0]  top_ptr,
  output logic [ADDR_W-1:0] top_addr,
  output logic [CTR_W-1:0]  top_ctr,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CTR_W-1:0]  rd_ctr
);
  logic              fire;
  logic              we;
  logic [PTR_W-1:0]  widx;
  logic [ADDR_W-1:0] waddr;
  logic [CTR_W-1:0]  wctr;

  assign cmt_ready = rst_n;
  assign fire      = cmt_valid && cmt_ready;

  crs_ptr_ctl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CTR_W(CTR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .fire(fire), .is_push(cmt_push),
    .push_addr(cmt_addr), .cur_addr(top_addr), .cur_ctr(top_ctr),
    .sp(top_ptr), .we(we), .widx(widx), .waddr(waddr), .wctr(wctr)
  );

  crs_entry_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CTR_W(CTR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .waddr(waddr), .wctr(wctr),
    .ra_idx(top_ptr), .ra_addr(top_addr), .ra_ctr(top_ctr),
    .rb_idx(rd_idx), .rb_addr(rd_addr), .rb_ctr(rd_ctr)
  );
endmodule

// File: rtl/crs_commit_stack_chk.sv
module crs_commit_stack_chk #(
  parameter int ADDR_W = 32,
  parameter int CTR_W  = 2,
  parameter int PTR_W  = 4,
  localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}}
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmt_valid,
  input logic              cmt_ready,
  input logic              cmt_push,
  input logic [ADDR_W-1:0] cmt_addr,
  input logic [PTR_W-1:0]  top_ptr,
  input logic [ADDR_W-1:0] top_addr,
  input logic [CTR_W-1:0]  top_ctr
);
  logic xfer;
  assign xfer = cmt_valid && cmt_ready;

  assert_push_fold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cmt_push && cmt_addr == top_addr && top_ctr != CMAX) |=>
      (top_ptr == $past(top_ptr) && top_ctr == CTR_W'($past(top_ctr) + 1'b1)
       && top_addr == $past(cmt_addr)));

  assert_push_grow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cmt_push && !(cmt_addr == top_addr && top_ctr != CMAX)) |=>
      (top_ptr == PTR_W'($past(top_ptr) + 1'b1) && top_ctr == '0
       && top_addr == $past(cmt_addr)));

  assert_pop_ctr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !cmt_push && top_ctr != '0) |=>
      (top_ptr == $past(top_ptr) && top_ctr == CTR_W'($past(top_ctr) - 1'b1)));

  assert_pop_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !cmt_push && top_ctr == '0) |=>
      (top_ptr == PTR_W'($past(top_ptr) - 1'b1)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmt_valid |=> ($stable(top_ptr) && $stable(top_addr) && $stable(top_ctr)));
endmodule

bind crs_commit_stack crs_commit_stack_chk #(
  .ADDR_W(ADDR_W), .CTR_W(CTR_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_ready(cmt_ready),
  .cmt_push(cmt_push), .cmt_addr(cmt_addr), .top_ptr(top_ptr),
  .top_addr(top_addr), .top_ctr(top_ctr)
);

// File: tb/test_crs_commit_stack.sv
`timescale 1ns/1ps
module test_crs_commit_stack;
  localparam int DEPTH = 16;
  localparam int AW    = 32;
  localparam int CW    = 2;
  localparam int PW    = 4;
  localparam int CMAX  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmt_valid = 1'b0;
  logic cmt_ready;
  logic cmt_push = 1'b0;
  logic [AW-1:0] cmt_addr = '0;
  logic [PW-1:0] top_ptr;
  logic [AW-1:0] top_addr;
  logic [CW-1:0] top_ctr;
  logic [PW-1:0] rd_idx = '0;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] rd_ctr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_addr [DEPTH];
  int            m_ctr  [DEPTH];
  int            m_sp;
  logic [15:0]   lfsr = 16'hACE1;

  always #5 clk = ~clk;

  crs_commit_stack #(.DEPTH(DEPTH), .ADDR_W(AW), .CTR_W(CW)) i_crs_commit_stack (
    .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_ready(cmt_ready),
    .cmt_push(cmt_push), .cmt_addr(cmt_addr), .top_ptr(top_ptr),
    .top_addr(top_addr), .top_ctr(top_ctr), .rd_idx(rd_idx),
    .rd_addr(rd_addr), .rd_ctr(rd_ctr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      finish_run();
    end
  end

  task automatic step(input logic v, input logic p, input logic [AW-1:0] a,
                      input logic [PW-1:0] idx);
    string req;
    @(negedge clk);
    cmt_valid = v; cmt_push = p; cmt_addr = a; rd_idx = idx;
    #1;
    chk("R8 read port before edge", {rd_addr, 30'd0, rd_ctr},
        {m_addr[idx], 30'd0, 2'(m_ctr[idx])});
    chk("R2 ready high", {63'd0, cmt_ready}, 64'd1);
    if (!v) req = "R10 idle";
    else if (p) begin
      if (m_addr[m_sp] == a && m_ctr[m_sp] != CMAX) begin
        req = "R3 fold";
        m_ctr[m_sp]++;
      end else begin
        req = (m_sp == DEPTH-1) ? "R7 grow wrap" : "R4 grow";
        m_sp = (m_sp + 1) % DEPTH;
        m_addr[m_sp] = a;
        m_ctr[m_sp] = 0;
      end
    end else begin
      if (m_ctr[m_sp] != 0) begin
        req = "R5 pop counter";
        m_ctr[m_sp]--;
      end else begin
        req = "R6 pop pointer";
        m_sp = (m_sp + DEPTH - 1) % DEPTH;
      end
    end
    @(posedge clk);
    #1;
    chk({req, " ptr"}, {60'd0, top_ptr}, 64'(m_sp));
    chk({req, " R9 top"}, {top_addr, 30'd0, top_ctr},
        {m_addr[m_sp], 30'd0, 2'(m_ctr[m_sp])});
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_addr[i] = '0; m_ctr[i] = 0; end
    m_sp = 0;
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", {63'd0, cmt_ready}, 64'd0);
    rst_n = 1'b1;
    // R1: sweep every slot through the read port after reset
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      rd_idx = PW'(i);
      #1;
      chk("R1 reset slot", {rd_addr, 30'd0, rd_ctr}, 64'd0);
    end
    chk("R1 reset pointer", {60'd0, top_ptr}, 64'd0);
    // R3/R4: fold up to saturation then grow
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 32'h0000_1000, PW'(m_sp));
    // R5/R6: unwind
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, '0, PW'(m_sp));
    // R7: distinct pushes around the wrap
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 32'h4000 + AW'(i*4), PW'((m_sp+1)%DEPTH));
    // R10: idle with garbage on the bus
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 32'hDEAD_BEEF, PW'(i));
    // mixed sweep
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [PW-1:0] idx;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: a = 32'h1000;
        2'd1: a = 32'h1004;
        default: a = 32'h2000;
      endcase
      case (i % 3)
        0: idx = PW'((m_sp + 1) % DEPTH);
        1: idx = PW'(m_sp);
        default: idx = PW'(i % DEPTH);
      endcase
      step(lfsr[5:3] != 3'd0, lfsr[8] ^ lfsr[2], a, idx);
    end
    finish_run();
  end
endmodule